// File: doc/BRIEF.md
# Bit-Serial SIMON 32/64 Cipher Engine

This block encrypts or decrypts one 32-bit block with the SIMON 32/64 cipher. It is built for the smallest area, not for speed. One round of the cipher is spread over 16 clock cycles, and each cycle handles a single bit of the 16-bit words. A one-bit round slice produces one bit of the new left word per cycle, and a one-bit key slice produces one bit of the next round key in the same cycle. Text and key sit in circular shift chains that move by one place per cycle. The word rotations the cipher needs are fixed tap points on those chains, chosen by the bit counter.

To use it, drive `start` high for one cycle with `mode`, `text_in` and `key_in` valid. The engine loads its chains on that edge and runs 32 rounds. It then raises `done` for one cycle with the answer on `result`, and holds that value until the next operation is accepted. For decryption, the key port carries the last four round keys. The key slice then runs the schedule backwards by swapping which key words feed its rotated and unrotated terms.

Top module: `simon_serial_core`

## Requirements
- R1: While reset is asserted, and after it is released with no operation started, `done` is 0 and `result` is all zeros.
- R2: With `mode`=0, `result` is the SIMON 32/64 encryption of `text_in`. `text_in[31:16]` is the left word and `text_in[15:0]` is the right word, and `result` uses the same layout. `key_in[15:0]` is round key 0, `[31:16]` is key 1, `[47:32]` is key 2 and `[63:48]` is key 3. Each new key word applies the constant 0xFFFC and the z0 sequence bit of its round.
- R3: With `mode`=1, `result` is the decryption of `text_in`. `key_in[15:0]` holds round key 31, `[31:16]` holds key 30, `[47:32]` holds key 29 and `[63:48]` holds key 28.
- R4: `done` rises exactly 512 clock edges (32 rounds × 16 bits) after the edge that accepted `start`.
- R5: `done` is high for exactly one cycle per operation.
- R6: While an operation runs, `start` is ignored. Changes on `mode`, `text_in` and `key_in` have no effect on that operation's result or timing.
- R7: `result` holds its value from `done` until the next accepted `start`.
- R8: A `start` given in the cycle where `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| mode | input | 1 | 0 encrypt, 1 decrypt; sampled with start |
| text_in | input | 32 | Plaintext or ciphertext block |
| key_in | input | 64 | Initial key words (encrypt) or final key words (decrypt) |
| result | output | 32 | Output block, valid from done onward |
| done | output | 1 | One-cycle completion pulse |

## Verification
Both `done` and the final `result` are due at the 512th rising edge after the edge that captures `start`. The bench sets `start` on a falling edge and counts falling edges from there. It expects `done` at count 512 exactly and reads `result` at that same count, away from the active edge. One falling edge later it checks that `done` has dropped, and over several further cycles it checks that `result` has not moved. Stray pulses and input changes are injected at known counts during a run, and the result and timing must still match the undisturbed expectation.

// File: rtl/simon_serial_pkg.sv
package simon_serial_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // z0 sequence, bit i applies to the key word made in round i
    localparam logic [61:0] ZSEQ = 62'h19C3522FB386A45F;
    localparam int          ZLEN = 62;

    // left rotations used by the round function f(x) = (x<<<A & x<<<B) ^ x<<<C
    localparam int ROT_A = 1;
    localparam int ROT_B = 8;
    localparam int ROT_C = 2;

endpackage

// File: rtl/simon_text_bit.sv
module simon_text_bit #(
    parameter int WORD = 16
) (
    input  logic [2*WORD-1:0]         chain,
    input  logic [$clog2(WORD)-1:0]   bitpos,
    input  logic                      rkey_bit,
    output logic                      new_bit
);
    import simon_serial_pkg::*;

    localparam int IW = $clog2(2*WORD);

    logic [IW-1:0] ia, ib, ic;
    logic          ta, tb, tc;

    // bit j-r of the left word: left word sits in the upper half, shifting right
    always_comb begin
        ia = (int'(bitpos) < ROT_A) ? IW'(2*WORD - ROT_A) : IW'(WORD - ROT_A);
        ib = (int'(bitpos) < ROT_B) ? IW'(2*WORD - ROT_B) : IW'(WORD - ROT_B);
        ic = (int'(bitpos) < ROT_C) ? IW'(2*WORD - ROT_C) : IW'(WORD - ROT_C);
        ta = chain[ia];
        tb = chain[ib];
        tc = chain[ic];
        new_bit = chain[0] ^ (ta & tb) ^ tc ^ rkey_bit;
    end

endmodule

// File: rtl/simon_key_bit.sv
module simon_key_bit #(
    parameter int WORD = 16
) (
    input  logic [4*WORD-1:0]         chain,
    input  logic [$clog2(WORD)-1:0]   bitpos,
    input  logic                      reverse,
    input  logic                      z_bit,
    output logic                      new_bit
);
    localparam int IW = $clog2(4*WORD);

    logic [IW-1:0] ia3, ia4, ib0, ib1;
    int            wa, wb;
    logic          cst;

    function automatic logic [IW-1:0] tap(input int w, input int d, input int j);
        if (j + d < WORD) return IW'(w*WORD + d);
        else              return IW'(w*WORD + d - WORD);
    endfunction

    always_comb begin
        // forward: rotated terms from newest word, plain terms from word 1
        // reverse: the two roles swap
        wa  = reverse ? 1 : 3;
        wb  = reverse ? 3 : 1;
        ia3 = tap(wa, 3, int'(bitpos));
        ia4 = tap(wa, 4, int'(bitpos));
        ib0 = tap(wb, 0, int'(bitpos));
        ib1 = tap(wb, 1, int'(bitpos));
        // inverted word XOR 3: constant is 1 except on bits 0 and 1
        cst = (int'(bitpos) >= 2);
        new_bit = chain[0] ^ chain[ia3] ^ chain[ia4] ^ chain[ib0] ^ chain[ib1]
                ^ cst ^ (z_bit & (bitpos == '0));
    end

endmodule

// File: rtl/simon_serial_core.sv
module simon_serial_core #(
    parameter int WORD   = 16,
    parameter int ROUNDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic [2*WORD-1:0] text_in,
    input  logic [4*WORD-1:0] key_in,
    output logic [2*WORD-1:0] result,
    output logic              done
);
    import simon_serial_pkg::*;

    localparam int TW = 2*WORD;
    localparam int KW = 4*WORD;
    localparam int BW = $clog2(WORD);
    localparam int RW = $clog2(ROUNDS);

    typedef struct packed {
        phase_e        phase;
        logic          dec;
        logic [BW-1:0] bitc;
        logic [RW-1:0] rnd;
        logic [TW-1:0] txt;
        logic [KW-1:0] key;
        logic          done;
    } state_t;

    state_t st_q, st_d;
    logic   txt_bit, key_bit, z_bit, running;
    int     zidx;

    assign running = (st_q.phase == PH_RUN);

    always_comb begin
        zidx  = st_q.dec ? (ROUNDS - 5 - int'(st_q.rnd)) : int'(st_q.rnd);
        z_bit = 1'b0;
        if (zidx >= 0 && zidx < ZLEN) z_bit = ZSEQ[zidx[5:0]];
    end

    simon_text_bit #(.WORD(WORD)) u_text (
        .chain   (st_q.txt),
        .bitpos  (st_q.bitc),
        .rkey_bit(st_q.key[0]),
        .new_bit (txt_bit)
    );

    simon_key_bit #(.WORD(WORD)) u_key (
        .chain  (st_q.key),
        .bitpos (st_q.bitc),
        .reverse(st_q.dec),
        .z_bit  (z_bit),
        .new_bit(key_bit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_RUN;
                    st_d.dec   = mode;
                    st_d.bitc  = '0;
                    st_d.rnd   = '0;
                    st_d.txt   = mode ? {text_in[WORD-1:0], text_in[TW-1:WORD]} : text_in;
                    st_d.key   = key_in;
                end
            end
            default: begin
                st_d.txt  = {txt_bit, st_q.txt[TW-1:1]};
                st_d.key  = {key_bit, st_q.key[KW-1:1]};
                st_d.bitc = st_q.bitc + 1'b1;
                if (st_q.bitc == BW'(WORD-1)) begin
                    st_d.rnd = st_q.rnd + 1'b1;
                    if (st_q.rnd == RW'(ROUNDS-1)) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.dec ? {st_q.txt[WORD-1:0], st_q.txt[TW-1:WORD]} : st_q.txt;
    assign done   = st_q.done;

endmodule

// File: rtl/simon_serial_chk.sv
module simon_serial_chk #(
    parameter int WORD   = 16,
    parameter int ROUNDS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              running,
    input logic              done,
    input logic [2*WORD-1:0] result
);
    localparam int TOTAL = WORD * ROUNDS;
    localparam int CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_cnt <= '0;
        else if (running) run_cnt <= run_cnt + 1'b1;
        else              run_cnt <= '0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!done && result == '0));

    // R4
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == CW'(TOTAL)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    run_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_cnt < CW'(TOTAL - 1)) |=> running);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && $past(!running) && !$past(start)) |-> $stable(result));

endmodule

bind simon_serial_core simon_serial_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .running(running),
    .done   (done),
    .result (result)
);

// File: tb/test_simon_serial_core.sv
module test_simon_serial_core;

    localparam int LAT = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] text_in = '0;
    logic [63:0] key_in = '0;
    logic [31:0] result;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    simon_serial_core i_simon_serial_core (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .text_in(text_in), .key_in(key_in), .result(result), .done(done)
    );

    function automatic logic [15:0] rol(input logic [15:0] v, input int r);
        return (v << r) | (v >> (16 - r));
    endfunction

    function automatic logic [15:0] fx(input logic [15:0] v);
        return (rol(v, 1) & rol(v, 8)) ^ rol(v, 2);
    endfunction

    function automatic void sched(input logic [63:0] k, output logic [15:0] ks [32]);
        logic [61:0] z = 62'h19C3522FB386A45F;
        logic [15:0] t;
        for (int i = 0; i < 4; i++) ks[i] = k[16*i +: 16];
        for (int i = 0; i < 28; i++) begin
            t = rol(ks[i+3], 13) ^ ks[i+1];
            t = t ^ rol(t, 15);
            ks[i+4] = ~ks[i] ^ t ^ {15'd0, z[i]} ^ 16'd3;
        end
    endfunction

    function automatic logic [31:0] ref_enc(input logic [31:0] p, input logic [63:0] k);
        logic [15:0] ks [32];
        logic [15:0] x, y, t;
        sched(k, ks);
        x = p[31:16]; y = p[15:0];
        for (int i = 0; i < 32; i++) begin
            t = x; x = y ^ fx(x) ^ ks[i]; y = t;
        end
        return {x, y};
    endfunction

    function automatic logic [31:0] ref_dec(input logic [31:0] c, input logic [63:0] k);
        logic [15:0] ks [32];
        logic [15:0] x, y, t;
        sched(k, ks);
        x = c[31:16]; y = c[15:0];
        for (int i = 31; i >= 0; i--) begin
            t = y; y = x ^ fx(y) ^ ks[i]; x = t;
        end
        return {x, y};
    endfunction

    function automatic logic [63:0] tail_key(input logic [63:0] k);
        logic [15:0] ks [32];
        sched(k, ks);
        return {ks[28], ks[29], ks[30], ks[31]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge where done is seen
    task automatic run_op(input logic m, input logic [31:0] t, input logic [63:0] k,
                          input int disturb, output logic [31:0] res, output int lat);
        start = 1'b1; mode = m; text_in = t; key_in = k;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        forever begin
            @(negedge clk);
            if (done) break;
            if (lat == disturb) begin
                start = 1'b1; mode = ~m; text_in = ~t; key_in = ~k;
            end else if (lat == disturb + 1) begin
                start = 1'b0;
            end
            lat++;
            if (lat > 2000) break;
        end
        start = 1'b0;
        res = result;
    endtask

    task automatic op_check(input logic m, input logic [31:0] t, input logic [63:0] k,
                            input logic [31:0] exp, input int disturb, input string req);
        logic [31:0] r;
        int          l;
        run_op(m, t, k, disturb, r, l);
        check(r == exp, req, 64'(r), 64'(exp));
        check(l == LAT, "R4 latency", 64'(l), 64'(LAT));
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] t, r, r2;
        logic [63:0] k;
        int          l;
        void'($urandom(32'h51A0));

        repeat (3) @(negedge clk);
        // R1 under reset
        check(!done && result == '0, "R1 in reset", {31'd0, done, result}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!done && result == '0, "R1 after reset", {31'd0, done, result}, 64'd0);

        // R2 known answer
        op_check(1'b0, 32'h65656877, 64'h1918111009080100, 32'hc69be9bb, -10, "R2 known vector");
        // R5 done drops
        @(negedge clk);
        check(!done, "R5 single pulse", 64'(done), 64'd0);
        // R7 result held while inputs wiggle
        text_in = '1; key_in = '1; mode = 1'b1;
        repeat (4) @(negedge clk);
        check(result == 32'hc69be9bb, "R7 hold", 64'(result), 64'hc69be9bb);

        // R3 known answer
        op_check(1'b1, 32'hc69be9bb, tail_key(64'h1918111009080100), 32'h65656877, -10, "R3 known vector");
        @(negedge clk);

        // R2/R3 corner patterns
        op_check(1'b0, 32'h0, 64'h0, ref_enc(32'h0, 64'h0), -10, "R2 all zero");
        @(negedge clk);
        op_check(1'b0, 32'hffffffff, '1, ref_enc(32'hffffffff, '1), -10, "R2 all ones");
        @(negedge clk);
        op_check(1'b1, 32'h0, tail_key(64'h0), ref_dec(32'h0, 64'h0), -10, "R3 all zero");
        @(negedge clk);

        // R6 disturbances at the first cycle, mid run and the last cycle
        op_check(1'b0, 32'h12345678, 64'h0f1e2d3c4b5a6978,
                 ref_enc(32'h12345678, 64'h0f1e2d3c4b5a6978), 1, "R6 early start");
        @(negedge clk);
        op_check(1'b1, 32'h9abcdef0, tail_key(64'h8877665544332211),
                 ref_dec(32'h9abcdef0, 64'h8877665544332211), 250, "R6 mid start");
        @(negedge clk);
        op_check(1'b0, 32'hdeadbeef, 64'h0123456789abcdef,
                 ref_enc(32'hdeadbeef, 64'h0123456789abcdef), LAT - 1, "R6 late start");
        @(negedge clk);

        // R8 back to back: start again in the done cycle
        t = 32'h0badf00d; k = 64'hcafef00d12345678;
        run_op(1'b0, t, k, -10, r, l);
        run_op(1'b1, r, tail_key(k), -10, r2, l);
        check(r2 == t, "R8 back to back", 64'(r2), 64'(t));
        check(l == LAT, "R8 latency", 64'(l), 64'(LAT));
        @(negedge clk);

        // random mix
        for (int i = 0; i < 12; i++) begin
            t = $urandom; k = {$urandom, $urandom};
            op_check(1'b0, t, k, ref_enc(t, k), -10, "R2 random");
            @(negedge clk);
            op_check(1'b1, t, tail_key(k), ref_dec(t, k), -10, "R3 random");
            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule